// File: doc/BRIEF.md
# Queued-Duty Pulse-Width Modulator

This block drives one pulse-width-modulated output from a period counter. Software programs it through a small word-wide register bus with four addresses: control, status, duty sample and period. Duty words are not applied at once. They enter a four-deep queue, and the generator takes one word from the queue at the start of every period. Software can therefore stay up to four periods ahead of the waveform. When the queue runs dry, the last duty value is used again.

The counter advances on ticks from a prescaler. The prescaler divides a selectable source by the prescale field plus one. The source is either the system clock or an external tick input, or the source can be switched off. One period lasts the period register value plus two ticks. The output is high from the period start until the counter reaches the active duty value.

Three request inputs (doze, wait, debug) pause the counter unless the matching run-enable bit is set. A self-clearing soft-reset bit returns every register to its reset value and empties the queue. This takes a fixed number of cycles, and the bit reads back as 1 until the reset is complete.

The core has three states: OFF, RUN and HOLD. Its transitions are:
- OFF→RUN when enable is set. This starts a period.
- RUN→HOLD when a pause request is not allowed by its run-enable bit.
- HOLD→RUN when that request condition clears.
- RUN→OFF and HOLD→OFF when enable is cleared.

The soft-reset sequencer has two states, IDLE and BUSY:
- IDLE→BUSY on a control write with bit 1 set.
- BUSY→IDLE after `RST_CYC` cycles.

Top module: `pwmq_top`

## Requirements
- R1: After reset, control, status, period and active-sample reads return 0, and `pwm_o` is low.
- R2: The duty queue holds 4 words. Status bits [2:0] report how many words are queued, and a value of 4 means full.
- R3: Each period start takes the oldest queued word as the active duty and frees one slot. Widths follow the write order.
- R4: A sample write to a full queue is dropped and sets sticky status bit 3. Writing 1 to status bit 3 clears it, and the queue is left unchanged.
- R5: Writing 1 to control bit 1 empties the queue and resets all registers. The bit reads 1 for `RST_CYC` (4) cycles and then 0. Register writes made while it reads 1 are ignored.
- R6: A period lasts (period register + 2) ticks, and `pwm_o` is high for the first (active duty) ticks of it.
- R7: With control bit 0 (enable) low, `pwm_o` is low and the counter is held at zero. Setting enable starts a period on the next cycle, with `pwm_o` high if the duty is nonzero.
- R8: Control bits [19:8] (prescale) divide the tick source by the field value plus 1.
- R9: If the queue is empty at a period start, the previous duty value is used again.
- R10: A period write takes effect at the next period start, and the current period keeps its length.
- R11: Control bits [3:2] select the tick source: 0 = none (the counter stops), 1 = system clock, 2 or 3 = the `ext_tick` input.
- R12: Each of `doze_req`, `wait_req` and `dbg_req` freezes the counter and the output unless its run bit is set: control bit 4 for doze, bit 5 for wait, bit 6 for debug.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 sample, 3 period |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Combinational read data for `bus_addr` |
| ext_tick | input | 1 | External tick source |
| doze_req | input | 1 | Doze-state request |
| wait_req | input | 1 | Wait-state request |
| dbg_req | input | 1 | Debug-halt request |
| pwm_o | output | 1 | Modulated output |

## Verification
A write is captured on the clock edge it meets, and read data follows combinationally. Status and control readback are therefore checked at the falling edge after the write. The core sees a new enable one edge later, so `pwm_o` is checked low at the first falling edge after the enable write and high at the second. Widths and period lengths are counted in whole cycles between two rising edges of `pwm_o`, sampled at falling edges, so the start-up phase never enters an expected value. Soft-reset status is read once while BUSY is still held and again after `RST_CYC` plus two cycles.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_SMPL = 2'd2;
    localparam logic [1:0] A_PER  = 2'd3;

    localparam int CB_EN     = 0;
    localparam int CB_SRST   = 1;
    localparam int CB_SEL    = 2;
    localparam int CB_DOZE   = 4;
    localparam int CB_WAIT   = 5;
    localparam int CB_DBG    = 6;
    localparam int CB_PRE    = 8;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } core_st_t;

    typedef enum logic {
        SR_IDLE = 1'b0,
        SR_BUSY = 1'b1
    } sr_st_t;

endpackage

// File: rtl/pwmq_fifo.sv
module pwmq_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head_o,
    output logic          empty_o,
    output logic          full_o,
    output logic [CW-1:0] count_o
);

    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          push_ok, pop_ok;

    assign full_o  = (cnt_q == CW'(DEPTH));
    assign empty_o = (cnt_q == '0);
    assign push_ok = push && !full_o;
    assign pop_ok  = pop && !empty_o;
    assign head_o  = mem_q[rp_q];
    assign count_o = cnt_q;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else if (flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) wp_q <= step(wp_q);
            if (pop_ok)  rp_q <= step(rp_q);
            unique case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[wp_q] <= push_data;
    end

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH)); // R2

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full_o && !pop && !flush) |=> (cnt_q == CW'(DEPTH))); // R4

endmodule

// File: rtl/pwmq_prescale.sv
module pwmq_prescale #(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [1:0]       sel,
    input  logic             ext_tick,
    input  logic             stall,
    input  logic [PRE_W-1:0] div,
    output logic             tick_o
);

    logic             src;
    logic             adv;
    logic [PRE_W-1:0] pcnt_q;

    always_comb begin
        unique case (sel)
            2'd0:    src = 1'b0;
            2'd1:    src = 1'b1;
            default: src = ext_tick;
        endcase
    end

    assign adv    = src && !stall && !clr;
    assign tick_o = adv && (pcnt_q >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pcnt_q <= '0;
        else if (clr)    pcnt_q <= '0;
        else if (tick_o) pcnt_q <= '0;
        else if (adv)    pcnt_q <= pcnt_q + PRE_W'(1);
    end

    AST_PRE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !tick_o) |=> (pcnt_q <= div || $past(div) != div)); // R8

endmodule

// File: rtl/pwmq_core.sv
module pwmq_core
    import pwmq_pkg::*;
#(
    parameter int PW = 16,
    localparam int CNTW = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic          freeze,
    input  logic          tick,
    input  logic [PW-1:0] per,
    input  logic          fifo_empty,
    input  logic [PW-1:0] fifo_head,
    output logic          pop_o,
    output logic          run_o,
    output logic [PW-1:0] smpl_o,
    output logic          pwm_o
);

    core_st_t        st_q, st_d;
    logic [CNTW-1:0] cnt_q;
    logic [PW-1:0]   act_per_q, act_smp_q;
    logic            wrap, start;

    assign wrap  = (cnt_q == ({1'b0, act_per_q} + CNTW'(1)));
    assign start = en && ((st_q == ST_OFF) || (st_q == ST_RUN && tick && wrap));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF:  if (en) st_d = ST_RUN;
            ST_RUN:  if (!en) st_d = ST_OFF;
                     else if (freeze) st_d = ST_HOLD;
            ST_HOLD: if (!en) st_d = ST_OFF;
                     else if (!freeze) st_d = ST_RUN;
            default: st_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   st_q <= ST_OFF;
        else if (clr) st_q <= ST_OFF;
        else          st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            act_per_q <= '0;
            act_smp_q <= '0;
        end else if (clr) begin
            cnt_q     <= '0;
            act_per_q <= '0;
            act_smp_q <= '0;
        end else if (start) begin
            cnt_q     <= '0;
            act_per_q <= per;
            if (!fifo_empty) act_smp_q <= fifo_head;
        end else if (!en || st_q == ST_OFF) begin
            cnt_q <= '0;
        end else if (st_q == ST_RUN && tick) begin
            cnt_q <= cnt_q + CNTW'(1);
        end
    end

    always_comb begin
        pop_o  = start && !fifo_empty;
        run_o  = (st_q != ST_OFF);
        smpl_o = act_smp_q;
        pwm_o  = (st_q != ST_OFF) && (cnt_q < {1'b0, act_smp_q});
    end

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pwm_o); // R7

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN) |-> (cnt_q <= {1'b0, act_per_q} + CNTW'(1))); // R6

    AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_o && !clr) |=> (cnt_q == '0)); // R3

    AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD && en && freeze && !clr) |=> $stable(cnt_q)); // R12

endmodule

// File: rtl/pwmq_top.sv
module pwmq_top
    import pwmq_pkg::*;
#(
    parameter int DW      = 32,
    parameter int PW      = 16,
    parameter int PRE_W   = 12,
    parameter int DEPTH   = 4,
    parameter int RST_CYC = 4,
    localparam int CW     = $clog2(DEPTH + 1),
    localparam int RCW    = $clog2(RST_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          ext_tick,
    input  logic          doze_req,
    input  logic          wait_req,
    input  logic          dbg_req,
    output logic          pwm_o
);

    sr_st_t           sr_q, sr_d;
    logic [RCW-1:0]   rcnt_q;
    logic             busy;

    logic             en_q, doze_run_q, wait_run_q, dbg_run_q, ovf_q;
    logic [1:0]       sel_q;
    logic [PRE_W-1:0] pre_q;
    logic [PW-1:0]    per_q;

    logic             wr_ok, wr_ctrl, wr_stat, wr_smpl, wr_per, srst_req;
    logic             freeze, tick, core_run, pop;
    logic             f_empty, f_full;
    logic [CW-1:0]    f_cnt;
    logic [PW-1:0]    f_head, smpl_act;
    logic             unused_wbits;

    assign busy     = (sr_q == SR_BUSY);
    assign wr_ok    = bus_wr && !busy;
    assign wr_ctrl  = wr_ok && (bus_addr == A_CTRL);
    assign wr_stat  = wr_ok && (bus_addr == A_STAT);
    assign wr_smpl  = wr_ok && (bus_addr == A_SMPL);
    assign wr_per   = wr_ok && (bus_addr == A_PER);
    assign srst_req = wr_ctrl && bus_wdata[CB_SRST];
    assign unused_wbits = ^{bus_wdata[DW-1:CB_PRE+PRE_W], bus_wdata[7]};

    always_comb begin
        sr_d = sr_q;
        unique case (sr_q)
            SR_IDLE: if (srst_req) sr_d = SR_BUSY;
            SR_BUSY: if (rcnt_q == RCW'(RST_CYC - 1)) sr_d = SR_IDLE;
            default: sr_d = SR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q   <= SR_IDLE;
            rcnt_q <= '0;
        end else begin
            sr_q   <= sr_d;
            rcnt_q <= (sr_q == SR_BUSY && sr_d == SR_BUSY) ? rcnt_q + RCW'(1) : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0; sel_q <= '0; pre_q <= '0;
            doze_run_q <= 1'b0; wait_run_q <= 1'b0; dbg_run_q <= 1'b0;
            per_q <= '0; ovf_q <= 1'b0;
        end else if (busy || srst_req) begin
            en_q <= 1'b0; sel_q <= '0; pre_q <= '0;
            doze_run_q <= 1'b0; wait_run_q <= 1'b0; dbg_run_q <= 1'b0;
            per_q <= '0; ovf_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                en_q       <= bus_wdata[CB_EN];
                sel_q      <= bus_wdata[CB_SEL +: 2];
                doze_run_q <= bus_wdata[CB_DOZE];
                wait_run_q <= bus_wdata[CB_WAIT];
                dbg_run_q  <= bus_wdata[CB_DBG];
                pre_q      <= bus_wdata[CB_PRE +: PRE_W];
            end
            if (wr_per) per_q <= bus_wdata[PW-1:0];
            if (wr_smpl && f_full)           ovf_q <= 1'b1;
            else if (wr_stat && bus_wdata[CW]) ovf_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL: begin
                bus_rdata[CB_EN]            = en_q;
                bus_rdata[CB_SRST]          = busy;
                bus_rdata[CB_SEL +: 2]      = sel_q;
                bus_rdata[CB_DOZE]          = doze_run_q;
                bus_rdata[CB_WAIT]          = wait_run_q;
                bus_rdata[CB_DBG]           = dbg_run_q;
                bus_rdata[CB_PRE +: PRE_W]  = pre_q;
            end
            A_STAT: begin
                bus_rdata[CW-1:0] = f_cnt;
                bus_rdata[CW]     = ovf_q;
            end
            A_SMPL:  bus_rdata[PW-1:0] = smpl_act;
            default: bus_rdata[PW-1:0] = per_q;
        endcase
    end

    assign freeze = (doze_req && !doze_run_q) ||
                    (wait_req && !wait_run_q) ||
                    (dbg_req  && !dbg_run_q);

    pwmq_fifo #(.W(PW), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (busy),
        .push      (wr_smpl),
        .push_data (bus_wdata[PW-1:0]),
        .pop       (pop),
        .head_o    (f_head),
        .empty_o   (f_empty),
        .full_o    (f_full),
        .count_o   (f_cnt)
    );

    pwmq_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (busy || !core_run),
        .sel      (sel_q),
        .ext_tick (ext_tick),
        .stall    (freeze),
        .div      (pre_q),
        .tick_o   (tick)
    );

    pwmq_core #(.PW(PW)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (busy),
        .en         (en_q),
        .freeze     (freeze),
        .tick       (tick),
        .per        (per_q),
        .fifo_empty (f_empty),
        .fifo_head  (f_head),
        .pop_o      (pop),
        .run_o      (core_run),
        .smpl_o     (smpl_act),
        .pwm_o      (pwm_o)
    );

    AST_SRST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> (f_cnt == '0)); // R5

    AST_SRST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rcnt_q < RCW'(RST_CYC))); // R5

    AST_BUSY_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (f_cnt == '0)); // R5

endmodule

// File: tb/sim_pwmq_top.sv
module sim_pwmq_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ext_tick = 1'b0;
    logic        ext_mode = 1'b0;
    logic        doze_req = 1'b0, wait_req = 1'b0, dbg_req = 1'b0;
    logic        pwm;

    int n_run = 0, n_fail = 0;
    int hi_a [8];
    int tot_a [8];

    always #5 clk = ~clk;

    always @(negedge clk) ext_tick <= ext_mode ? ~ext_tick : 1'b0;

    pwmq_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_tick(ext_tick),
        .doze_req(doze_req), .wait_req(wait_req), .dbg_req(dbg_req), .pwm_o(pwm)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int d);
        bus_addr = a;
        #1;
        d = int'(bus_rdata);
    endtask

    function automatic logic [31:0] cv(input bit en, input int sel, input int pre,
                                       input bit dz, input bit wt, input bit db);
        return 32'(en) | (32'(sel) << 2) | (32'(dz) << 4) | (32'(wt) << 5)
             | (32'(db) << 6) | (32'(pre) << 8);
    endfunction

    task automatic sreset();
        wr(2'd0, 32'h2);
        repeat (8) @(negedge clk);
    endtask

    task automatic meas_seq(input int n);
        logic p;
        int g = 0;
        for (int k = 0; k < 8; k++) begin hi_a[k] = -1; tot_a[k] = -1; end
        do begin p = pwm; @(negedge clk); g++; end while (!(!p && pwm) && g < 5000);
        for (int k = 0; k < n; k++) begin
            int hi = 0, tot = 0;
            do begin
                hi += int'(pwm); tot++; p = pwm; @(negedge clk); g++;
            end while (!(!p && pwm) && g < 5000);
            hi_a[k] = hi; tot_a[k] = tot;
        end
    endtask

    task automatic t_reset();
        int d;
        rd(2'd0, d); check("R1 ctrl", d, 0);
        rd(2'd1, d); check("R1 status", d, 0);
        rd(2'd3, d); check("R1 period", d, 0);
        rd(2'd2, d); check("R1 sample", d, 0);
        check("R1 pwm", int'(pwm), 0);
    endtask

    task automatic t_order();
        int d;
        sreset();
        wr(2'd3, 8);
        wr(2'd2, 2); wr(2'd2, 4); wr(2'd2, 6);
        rd(2'd1, d); check("R2 count3", d, 3);
        wr(2'd0, cv(1, 1, 0, 0, 0, 0));
        meas_seq(4);
        check("R3 w0", hi_a[0], 2);
        check("R3 w1", hi_a[1], 4);
        check("R3 w2", hi_a[2], 6);
        check("R9 repeat", hi_a[3], 6);
        check("R6 period", tot_a[0], 10);
        check("R6 period2", tot_a[3], 10);
        rd(2'd1, d); check("R3 drained", d, 0);
    endtask

    task automatic t_overflow();
        int d;
        sreset();
        for (int i = 1; i <= 5; i++) wr(2'd2, 32'(i));
        rd(2'd1, d); check("R4 full+ovf", d, 12);
        wr(2'd1, 32'h8);
        rd(2'd1, d); check("R4 w1c", d, 4);
        wr(2'd3, 8);
        wr(2'd0, cv(1, 1, 0, 0, 0, 0));
        meas_seq(5);
        check("R4 q0", hi_a[0], 1);
        check("R4 q3", hi_a[3], 4);
        check("R4 dropped", hi_a[4], 4);
    endtask

    task automatic t_period_update();
        logic p;
        int c = 0;
        sreset();
        wr(2'd3, 8); wr(2'd2, 2);
        wr(2'd0, cv(1, 1, 0, 0, 0, 0));
        meas_seq(1);
        check("R10 before", tot_a[0], 10);
        wr(2'd3, 4);
        p = pwm;
        do begin p = pwm; @(negedge clk); c++; end while (!(!p && pwm) && c < 100);
        check("R10 current kept", c, 9);
        meas_seq(2);
        check("R10 new", tot_a[0], 6);
        check("R10 new2", tot_a[1], 6);
    endtask

    task automatic t_prescale();
        sreset();
        wr(2'd3, 3); wr(2'd2, 2);
        wr(2'd0, cv(1, 1, 2, 0, 0, 0));
        meas_seq(2);
        check("R8 high", hi_a[1], 6);
        check("R8 period", tot_a[1], 15);
    endtask

    task automatic t_disable();
        int d, h = 0;
        sreset();
        wr(2'd3, 8); wr(2'd2, 5);
        wr(2'd0, cv(1, 1, 0, 0, 0, 0));
        repeat (3) @(negedge clk);
        wr(2'd0, cv(0, 1, 0, 0, 0, 0));
        @(negedge clk);
        for (int i = 0; i < 20; i++) begin h += int'(pwm); @(negedge clk); end
        check("R7 low when off", h, 0);
        rd(2'd2, d); check("R7 duty kept", d, 5);
        wr(2'd0, cv(1, 1, 0, 0, 0, 0));
        check("R7 still low", int'(pwm), 0);
        @(negedge clk);
        check("R7 restart high", int'(pwm), 1);
    endtask

    task automatic t_clksel();
        int h = 0;
        sreset();
        wr(2'd3, 3); wr(2'd2, 2);
        wr(2'd0, cv(1, 0, 0, 0, 0, 0));
        repeat (3) @(negedge clk);
        for (int i = 0; i < 40; i++) begin h += int'(pwm); @(negedge clk); end
        check("R11 sel0 stopped", h, 40);
        ext_mode = 1'b1;
        wr(2'd0, cv(1, 2, 0, 0, 0, 0));
        meas_seq(2);
        check("R11 ext high", hi_a[1], 4);
        check("R11 ext period", tot_a[1], 10);
        ext_mode = 1'b0;
    endtask

    task automatic t_hold();
        int tg = 0;
        logic p;
        sreset();
        wr(2'd3, 8); wr(2'd2, 4);
        wr(2'd0, cv(1, 1, 0, 0, 0, 0));
        repeat (2) @(negedge clk);
        dbg_req = 1'b1;
        @(negedge clk);
        p = pwm;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (pwm != p) tg++;
            p = pwm;
        end
        check("R12 frozen", tg, 0);
        wr(2'd0, cv(1, 1, 0, 0, 0, 1));
        meas_seq(1);
        check("R12 run bit", tot_a[0], 10);
        dbg_req = 1'b0;
    endtask

    task automatic t_soft_reset();
        int d;
        sreset();
        wr(2'd3, 9); wr(2'd2, 7); wr(2'd2, 7);
        wr(2'd0, cv(1, 1, 5, 1, 1, 1));
        wr(2'd0, 32'h2);
        rd(2'd0, d); check("R5 busy", d & 2, 2);
        wr(2'd3, 6);
        rd(2'd0, d); check("R5 busy still", d & 2, 2);
        repeat (6) @(negedge clk);
        rd(2'd0, d); check("R5 ctrl cleared", d, 0);
        rd(2'd1, d); check("R5 flushed", d, 0);
        rd(2'd3, d); check("R5 period ignored", d, 0);
        check("R5 pwm low", int'(pwm), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_overflow();
        t_period_update();
        t_prescale();
        t_disable();
        t_clksel();
        t_hold();
        t_soft_reset();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule